// File: doc/BRIEF.md
# Complex Cross-Product Statistics Accumulator

The block integrates complex cross-products of two time-multiplexed complex sample streams, A and B, over one sync interval. Every accepted sample belongs to one statistic index; the block multiplies A by the complex conjugate of B and adds the product into that index's accumulator. The accumulators live in an internal two-port memory whose read data arrives two cycles after the address, so the update is a pipelined read-modify-write.

Data arrives in blocks of `CROSSLETS * INPUTS * INPUTS` samples. Within a block the crosslet changes slowest, then the A input, and the B input changes fastest. A single-cycle sync pulse, given together with the first sample of a block, closes the running interval. During the block that follows, each index emits its finished sum once, with its address and a one-cycle strobe, and then starts a fresh sum from that block's sample. A downstream statistics register or readout bus takes the emitted words.

Top module: `xstat_acc`

## Requirements
- R1: For each sample the real sum gains `a_re*b_re + a_im*b_im` and the imaginary sum gains `a_im*b_re - a_re*b_im`. Both are kept as separate signed two's complement accumulators of `ACC_W` bits.
- R2: Statistic index k = (c*INPUTS + a)*INPUTS + b for crosslet c, A input a and B input b. The index advances by one on every valid sample and wraps from `N_STAT-1` to 0, with `N_STAT = CROSSLETS*INPUTS*INPUTS`.
- R3: A sample presented in the same cycle as `sync_i` is handled as index 0 of a new interval.
- R4: After a sync, the first sample of each index makes the previous sum of that index appear on `stat_re_o`/`stat_im_o`, with `stat_addr_o` equal to the index and `stat_valid_o` high for exactly one cycle. This happens three rising edges after the edge that accepts the sample.
- R5: The sample that triggers an emission starts the new sum from zero. The new sum is that sample's product alone, with no part of the old sum.
- R6: Cycles with `valid_i` low change no accumulator and do not advance the index, whatever data is on the inputs.
- R7: Accumulators wrap modulo 2^ACC_W on overflow and do not saturate.
- R8: After reset, `stat_valid_o` stays low until the first sync. The first `N_STAT` samples after reset start their sums from zero.
- R9: The accumulation memory has a read latency of two cycles and `N_STAT` must be at least 8. An index is never read while a write to the same index is still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_re_i | input | IN_W | Stream A real part, signed |
| a_im_i | input | IN_W | Stream A imaginary part, signed |
| b_re_i | input | IN_W | Stream B real part, signed |
| b_im_i | input | IN_W | Stream B imaginary part, signed |
| valid_i | input | 1 | Sample qualifier |
| sync_i | input | 1 | Interval boundary pulse, given with the first sample of a block |
| stat_addr_o | output | $clog2(N_STAT) | Index of the emitted statistic |
| stat_re_o | output | ACC_W | Emitted real sum, signed |
| stat_im_o | output | ACC_W | Emitted imaginary sum, signed |
| stat_valid_o | output | 1 | One-cycle write strobe per emitted index |

## Verification
In one cycle the last stage emits an index's closing sum and writes that same index's restarted sum. In the same cycle, the sync edge resets the index counter while the previous interval's final samples are still in the pipeline. The bench provokes both by sending blocks back to back, with the sync on the sample right after the last sample of the preceding block, and by sending blocks separated by gaps of garbage data. It judges every emitted word against a reference computed arithmetically in the bench from the driven samples: address, real and imaginary values, and the exact output cycle. Any output the reference does not expect, or any expected output that never appears, is a failure.

// File: rtl/xstat_pkg.sv
package xstat_pkg;
  localparam int unsigned MIN_STATS  = 8;
  localparam int unsigned MEM_RD_LAT = 2;

  typedef struct packed {
    logic valid;
    logic first;  // first sample of this index in the interval
    logic emit;   // previous sum goes to the output
  } ctl_t;
endpackage

// File: rtl/xstat_cmul.sv
// A * conj(B), three register stages: input, partial products, sums.
module xstat_cmul #(
  parameter int unsigned IN_W  = 18,
  parameter int unsigned ACC_W = 54
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  a_re_i,
  input  logic signed [IN_W-1:0]  a_im_i,
  input  logic signed [IN_W-1:0]  b_re_i,
  input  logic signed [IN_W-1:0]  b_im_i,
  output logic signed [ACC_W-1:0] prod_re_o,
  output logic signed [ACC_W-1:0] prod_im_o
);
  localparam int unsigned PW = 2 * IN_W;
  localparam int unsigned XW = ACC_W - PW;

  logic signed [IN_W-1:0] ar_q, ai_q, br_q, bi_q;
  logic signed [PW-1:0]   rr_q, ii_q, ir_q, ri_q;
  logic signed [ACC_W-1:0] rr_x, ii_x, ir_x, ri_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q <= '0;
      ai_q <= '0;
      br_q <= '0;
      bi_q <= '0;
    end else begin
      ar_q <= a_re_i;
      ai_q <= a_im_i;
      br_q <= b_re_i;
      bi_q <= b_im_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
      ii_q <= '0;
      ir_q <= '0;
      ri_q <= '0;
    end else begin
      rr_q <= ar_q * br_q;
      ii_q <= ai_q * bi_q;
      ir_q <= ai_q * br_q;
      ri_q <= ar_q * bi_q;
    end
  end

  assign rr_x = {{XW{rr_q[PW-1]}}, rr_q};
  assign ii_x = {{XW{ii_q[PW-1]}}, ii_q};
  assign ir_x = {{XW{ir_q[PW-1]}}, ir_q};
  assign ri_x = {{XW{ri_q[PW-1]}}, ri_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_re_o <= '0;
      prod_im_o <= '0;
    end else begin
      prod_re_o <= rr_x + ii_x;
      prod_im_o <= ir_x - ri_x;
    end
  end
endmodule

// File: rtl/xstat_mem.sv
// Simple two-port accumulation store, two-cycle read latency.
module xstat_mem #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned W     = 108
) (
  input  logic          clk_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i
);
  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i) begin
    rd_q      <= mem_q[rd_addr_i];
    rd_data_o <= rd_q;
  end
endmodule

// File: rtl/xstat_seq.sv
// Index counter, restart window and control pipeline aligned to the memory.
module xstat_seq
  import xstat_pkg::*;
#(
  parameter int unsigned N_STAT = 8,
  parameter int unsigned AW     = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sync_i,
  output logic          s1_valid_o,
  output logic [AW-1:0] s1_addr_o,
  output logic          s2_valid_o,
  output logic [AW-1:0] s2_addr_o,
  output ctl_t          s3_ctl_o,
  output logic [AW-1:0] s3_addr_o
);
  localparam int unsigned CW = $clog2(N_STAT + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(N_STAT - 1);
  localparam logic [CW-1:0] CLR_INIT = CW'(N_STAT);

  logic          s1_valid_q;
  logic [AW-1:0] idx_q;
  logic [CW-1:0] clr_cnt_q;
  logic          emit_en_q;
  ctl_t          s1_ctl, s2_ctl_q, s3_ctl_q;
  logic [AW-1:0] s2_addr_q, s3_addr_q;

  always_comb begin
    s1_ctl.valid = s1_valid_q;
    s1_ctl.first = s1_valid_q && (clr_cnt_q != '0);
    s1_ctl.emit  = s1_ctl.first && emit_en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      idx_q      <= '0;
      clr_cnt_q  <= CLR_INIT;
      emit_en_q  <= 1'b0;
    end else begin
      s1_valid_q <= valid_i;
      if (sync_i) begin
        // sample arriving with sync enters s1 together with index 0
        idx_q     <= '0;
        clr_cnt_q <= CLR_INIT;
        emit_en_q <= 1'b1;
      end else if (s1_valid_q) begin
        idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        if (clr_cnt_q != '0) clr_cnt_q <= clr_cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_ctl_q  <= '0;
      s3_ctl_q  <= '0;
      s2_addr_q <= '0;
      s3_addr_q <= '0;
    end else begin
      s2_ctl_q  <= s1_ctl;
      s3_ctl_q  <= s2_ctl_q;
      s2_addr_q <= idx_q;
      s3_addr_q <= s2_addr_q;
    end
  end

  assign s1_valid_o = s1_valid_q;
  assign s1_addr_o  = idx_q;
  assign s2_valid_o = s2_ctl_q.valid;
  assign s2_addr_o  = s2_addr_q;
  assign s3_ctl_o   = s3_ctl_q;
  assign s3_addr_o  = s3_addr_q;
endmodule

// File: rtl/xstat_acc.sv
module xstat_acc
  import xstat_pkg::*;
#(
  parameter int unsigned CROSSLETS = 2,
  parameter int unsigned INPUTS    = 2,
  parameter int unsigned IN_W      = 18,
  parameter int unsigned ACC_W     = 54,
  localparam int unsigned N_STAT   = CROSSLETS * INPUTS * INPUTS,
  localparam int unsigned AW       = $clog2(N_STAT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IN_W-1:0]   a_re_i,
  input  logic [IN_W-1:0]   a_im_i,
  input  logic [IN_W-1:0]   b_re_i,
  input  logic [IN_W-1:0]   b_im_i,
  input  logic              valid_i,
  input  logic              sync_i,
  output logic [AW-1:0]     stat_addr_o,
  output logic [ACC_W-1:0]  stat_re_o,
  output logic [ACC_W-1:0]  stat_im_o,
  output logic              stat_valid_o
);
  localparam int unsigned MW = 2 * ACC_W;

  if (N_STAT < MIN_STATS) begin : g_too_few_stats
    $error("xstat_acc: N_STAT below minimum");
  end
  if (ACC_W <= 2 * IN_W) begin : g_acc_too_narrow
    $error("xstat_acc: ACC_W must exceed 2*IN_W");
  end

  logic                    s1_valid, s2_valid;
  logic [AW-1:0]           s1_addr, s2_addr, s3_addr;
  ctl_t                    s3_ctl;
  logic signed [ACC_W-1:0] prod_re, prod_im;
  logic [MW-1:0]           rd_data, wr_data;
  logic signed [ACC_W-1:0] old_re, old_im, new_re, new_im;

  xstat_seq #(.N_STAT(N_STAT), .AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .sync_i     (sync_i),
    .s1_valid_o (s1_valid),
    .s1_addr_o  (s1_addr),
    .s2_valid_o (s2_valid),
    .s2_addr_o  (s2_addr),
    .s3_ctl_o   (s3_ctl),
    .s3_addr_o  (s3_addr)
  );

  xstat_cmul #(.IN_W(IN_W), .ACC_W(ACC_W)) u_cmul (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_re_i    ($signed(a_re_i)),
    .a_im_i    ($signed(a_im_i)),
    .b_re_i    ($signed(b_re_i)),
    .b_im_i    ($signed(b_im_i)),
    .prod_re_o (prod_re),
    .prod_im_o (prod_im)
  );

  xstat_mem #(.DEPTH(N_STAT), .AW(AW), .W(MW)) u_mem (
    .clk_i     (clk_i),
    .rd_addr_i (s1_addr),
    .rd_data_o (rd_data),
    .wr_en_i   (s3_ctl.valid),
    .wr_addr_i (s3_addr),
    .wr_data_i (wr_data)
  );

  assign old_re  = $signed(rd_data[MW-1:ACC_W]);
  assign old_im  = $signed(rd_data[ACC_W-1:0]);
  // restart discards the stored sum; wrap on overflow
  assign new_re  = s3_ctl.first ? prod_re : old_re + prod_re;
  assign new_im  = s3_ctl.first ? prod_im : old_im + prod_im;
  assign wr_data = {new_re, new_im};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_valid_o <= 1'b0;
      stat_addr_o  <= '0;
      stat_re_o    <= '0;
      stat_im_o    <= '0;
    end else begin
      stat_valid_o <= s3_ctl.emit;
      if (s3_ctl.emit) begin
        stat_addr_o <= s3_addr;
        stat_re_o   <= old_re;
        stat_im_o   <= old_im;
      end
    end
  end
endmodule

// File: rtl/xstat_acc_chk.sv
module xstat_acc_chk #(
  parameter int unsigned AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          sync_i,
  input logic          stat_valid_o,
  input logic [AW-1:0] stat_addr_o,
  input logic          s1_valid,
  input logic [AW-1:0] s1_addr,
  input logic          s2_valid,
  input logic [AW-1:0] s2_addr,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);
  logic [1:0] age_q;
  logic       seen_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q       <= '0;
      seen_sync_q <= 1'b0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 1'b1;
      if (sync_i) seen_sync_q <= 1'b1;
    end
  end

  AST_NO_RMW_HAZARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |-> !(s2_valid && s2_addr == s1_addr) && !(wr_en && wr_addr == s1_addr)); // R9

  AST_SYNC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (s1_addr == '0)); // R3

  AST_GAP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !$past(valid_i, 3)) |-> !wr_en); // R6

  AST_OUT_ONE_PER_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && stat_valid_o && $past(stat_valid_o)) |-> stat_addr_o != $past(stat_addr_o)); // R4

  AST_QUIET_BEFORE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_sync_q |-> !stat_valid_o); // R8
endmodule

bind xstat_acc xstat_acc_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .sync_i       (sync_i),
  .stat_valid_o (stat_valid_o),
  .stat_addr_o  (stat_addr_o),
  .s1_valid     (s1_valid),
  .s1_addr      (s1_addr),
  .s2_valid     (s2_valid),
  .s2_addr      (s2_addr),
  .wr_en        (s3_ctl.valid),
  .wr_addr      (s3_addr)
);

// File: tb/xstat_acc_tb.sv
module xstat_acc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CROSS = 2;
  localparam int INP   = 2;
  localparam int IN_W  = 4;
  localparam int ACC_W = 12;
  localparam int N     = CROSS * INP * INP;
  localparam int AW    = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IN_W-1:0] a_re_i = '0, a_im_i = '0, b_re_i = '0, b_im_i = '0;
  logic valid_i = 1'b0, sync_i = 1'b0;
  logic [AW-1:0]    stat_addr_o;
  logic [ACC_W-1:0] stat_re_o, stat_im_o;
  logic             stat_valid_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xstat_acc #(.CROSSLETS(CROSS), .INPUTS(INP), .IN_W(IN_W), .ACC_W(ACC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_re_i(a_re_i), .a_im_i(a_im_i), .b_re_i(b_re_i), .b_im_i(b_im_i),
    .valid_i(valid_i), .sync_i(sync_i),
    .stat_addr_o(stat_addr_o), .stat_re_o(stat_re_o), .stat_im_o(stat_im_o),
    .stat_valid_o(stat_valid_o)
  );

  int n_checks = 0, n_fail = 0, n_out = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  longint m_re [N], m_im [N];
  int m_idx = 0, m_clr = N;
  bit m_emit_en = 0;
  string cur_tag = "R1";
  int q_idx[$];
  longint q_re[$], q_im[$], q_cyc[$];
  string q_tag[$];
  int av_re[CROSS*INP], av_im[CROSS*INP], bv_re[CROSS*INP], bv_im[CROSS*INP];

  function automatic longint wrapv(longint x);
    longint y;
    y = x & ((64'sd1 <<< ACC_W) - 1);
    if (y >= (64'sd1 <<< (ACC_W - 1))) y = y - (64'sd1 <<< ACC_W);
    return y;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit v, bit s, int ar, int ai, int br, int bi);
    longint pr, pi;
    @(negedge clk);
    valid_i = v; sync_i = s;
    a_re_i = IN_W'(ar); a_im_i = IN_W'(ai); b_re_i = IN_W'(br); b_im_i = IN_W'(bi);
    if (s) begin m_idx = 0; m_clr = N; m_emit_en = 1; end
    if (v) begin
      pr = longint'(ar * br + ai * bi);
      pi = longint'(ai * br - ar * bi);
      if (m_clr > 0) begin
        if (m_emit_en) begin
          q_idx.push_back(m_idx); q_re.push_back(m_re[m_idx]); q_im.push_back(m_im[m_idx]);
          q_cyc.push_back(cyc + 1 + 3); q_tag.push_back(cur_tag);
        end
        m_re[m_idx] = wrapv(pr); m_im[m_idx] = wrapv(pi);
        m_clr--;
      end else begin
        m_re[m_idx] = wrapv(m_re[m_idx] + pr); m_im[m_idx] = wrapv(m_im[m_idx] + pi);
      end
      m_idx = (m_idx + 1) % N;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, (i * 5) % 16 - 8, 7 - i % 16, -8, 7);
  endtask

  // R2 order: crosslet, A input, B input fastest
  task automatic send_block(bit with_sync, int gap, bit mid_gap);
    int k;
    k = 0;
    for (int c = 0; c < CROSS; c++)
      for (int a = 0; a < INP; a++)
        for (int b = 0; b < INP; b++) begin
          drive(1, with_sync && k == 0, av_re[c*INP+a], av_im[c*INP+a], bv_re[c*INP+b], bv_im[c*INP+b]);
          if (mid_gap && k == 2) idle(1);
          k++;
        end
    idle(gap);
  endtask

  task automatic set_data(int seed);
    for (int i = 0; i < CROSS * INP; i++) begin
      av_re[i] = ((i * 3 + seed) % 16) - 8;
      av_im[i] = ((i * 5 + seed * 7 + 3) % 16) - 8;
      bv_re[i] = ((i * 7 + seed * 3 + 1) % 16) - 8;
      bv_im[i] = ((i * 11 + seed * 5 + 9) % 16) - 8;
    end
  endtask

  task automatic set_const(int ar, int ai, int br, int bi);
    for (int i = 0; i < CROSS * INP; i++) begin
      av_re[i] = ar; av_im[i] = ai; bv_re[i] = br; bv_im[i] = bi;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && stat_valid_o) begin
      n_out++;
      if (q_idx.size() == 0) begin
        check(0, "R8", "unexpected stat_valid_o at addr", longint'(stat_addr_o), -1);
      end else begin
        int ei; longint er, eim, ec; string t;
        ei = q_idx.pop_front(); er = q_re.pop_front(); eim = q_im.pop_front();
        ec = q_cyc.pop_front(); t = q_tag.pop_front();
        check(stat_addr_o == AW'(ei), {t, " R2 R4"}, "addr", longint'(stat_addr_o), ei);
        check(longint'($signed(stat_re_o)) == er, {t, " R1 R5"}, "re", longint'($signed(stat_re_o)), er);
        check(longint'($signed(stat_im_o)) == eim, {t, " R1 R5"}, "im", longint'($signed(stat_im_o)), eim);
        check(cyc == ec, "R4", "output cycle", cyc, ec);
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_re[i] = 0; m_im[i] = 0; end
    repeat (3) @(negedge clk);
    check(stat_valid_o == 1'b0, "R8", "valid in reset", longint'(stat_valid_o), 0);
    rst_n = 1'b1;
    idle(2);
    check(stat_valid_o == 1'b0, "R8", "valid after reset", longint'(stat_valid_o), 0);

    // R8: data before the first sync; no outputs allowed
    cur_tag = "R8";
    set_data(1);
    send_block(0, 3, 0);
    send_block(0, 2, 0);
    idle(6);
    check(n_out == 0, "R8", "outputs before first sync", n_out, 0);

    // R3 R6: first sync, blocks with garbage gaps and a mid-block gap
    cur_tag = "R3 R8";
    set_data(2);
    send_block(1, 5, 0);
    cur_tag = "R6";
    for (int j = 0; j < 4; j++) send_block(0, 3 + j, j == 1);

    // R5 sweep: back-to-back intervals, sync straight after last sample
    for (int s = 3; s < 9; s++) begin
      cur_tag = "R5";
      set_data(s);
      send_block(1, 0, 0);
      for (int j = 0; j < s % 3; j++) send_block(0, 0, 0);
    end

    // R7: large constant products overflow the 12-bit sum
    cur_tag = "R7";
    set_const(-8, 7, -8, -8);
    send_block(1, 1, 0);
    for (int j = 0; j < 24; j++) send_block(0, 0, 0);
    cur_tag = "R7";
    set_data(11);
    send_block(1, 2, 0);
    send_block(1, 2, 0);
    idle(10);
    check(q_idx.size() == 0, "R4", "missing outputs", q_idx.size(), 0);
    check(n_out == 8 * 10, "R4", "output count", n_out, 8 * 10);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R4 watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule